// File: doc/BRIEF.md
# Receive Data Packer With Two-Stage Buffer

This block sits on the receive side of a narrow external parallel bus. Each read cycle of that bus delivers either an 8-bit or a 16-bit sample. The block gathers successive samples into a 32-bit word in a first-stage packing register. When that word is complete, it moves into a second-stage 32-bit holding register. The processor core or a DMA engine drains the holding register through a valid/ready handshake.

The two stages give exactly one word of slack. A finished word can wait in the packing register while the reader has not yet taken the previous word. When both stages hold a complete word, the block drops its permission output. The external bus sequencer must then start no new read transfer until the reader frees the holding register. Either a flush request or a change of the width select throws away all packing progress and both buffered words.

Top module: `rx_word_packer`

## Requirements
- R1: After a synchronous reset, `hold_valid` is 0 and `start_ok` is 1.
- R2: In byte mode (`wide_mode` = 0), four accepted samples form one word. Only `samp_data[7:0]` is used. The first sample lands in bits 7:0, and each later sample lands in the next higher byte.
- R3: In halfword mode (`wide_mode` = 1), two accepted samples form one word. The first sample lands in bits 15:0 and the second in bits 31:16.
- R4: If the holding register is empty at the clock edge that captures the last sample of a word, `hold_valid` is 1 from that edge on and `hold_data` carries the word.
- R5: If the holding register is full when a word completes, the word waits in the packing stage. After the edge at which the reader takes the held word, `hold_valid` is 0 for exactly one cycle. The waiting word is then loaded at the following edge.
- R6: `start_ok` is 0 exactly when both the packing stage and the holding register contain a complete word.
- R7: A sample presented while both stages are full is discarded. It appears in no later word.
- R8: While `hold_valid` is 1 and `hold_ready` is 0, `hold_valid` stays 1 and `hold_data` is unchanged. An edge with both signals at 1 hands over the word exactly once. Words leave in the order they were completed, with none lost or repeated.
- R9: An edge with `flush` = 1 discards the partial word, the waiting word and the held word, and ignores any sample presented at that edge. Afterwards `hold_valid` is 0, `start_ok` is 1, and packing restarts at the lowest lane.
- R10: An edge at which `wide_mode` differs from its value at the previous edge has the same clearing effect as a flush.
- R11: An edge with `samp_valid` = 0 changes no packing state, whatever `samp_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | Width select: 0 selects 8-bit samples, 1 selects 16-bit samples |
| flush | input | 1 | Discards all packing and buffered state |
| samp_valid | input | 1 | A bus sample is present this cycle |
| samp_data | input | 16 | Bus sample; only the low byte is used in byte mode |
| hold_data | output | 32 | Contents of the holding register |
| hold_valid | output | 1 | The holding register contains an unread word |
| hold_ready | input | 1 | The reader accepts the held word at this edge |
| start_ok | output | 1 | The bus sequencer may start a new read transfer |

## Verification
The hardest state to reach from the ports is the stalled state. In it, the holding register is unread, a second word is waiting in the packing stage, and more samples keep arriving. The directed stimulus holds `hold_ready` low across eight byte samples so that both stages fill. It then offers an extra byte that must vanish. Next it pulses `hold_ready` for one cycle, to show the one-cycle gap before the waiting word moves up. A long random phase then mixes sample bursts, reader stalls, mode flips and flushes. A behavioural reference model, kept as a queue of captured lanes, is compared against the outputs on every cycle.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic {
    LANE_BYTE = 1'b0,
    LANE_HALF = 1'b1
  } lane_mode_e;

  function automatic int lanes_per_word(input int word_w, input int lane_w);
    return word_w / lane_w;
  endfunction
endpackage

// File: rtl/rxp_clear_ctl.sv
module rxp_clear_ctl (
  input  logic clk,
  input  logic flush,
  input  logic wide_in,
  output logic clr
);
  logic mode_q;

  // The mode is remembered on every edge, reset included, so that a steady
  // width select never produces a clear.
  always_ff @(posedge clk) begin
    mode_q <= wide_in;
  end

  assign clr = flush | (wide_in != mode_q);
endmodule

// File: rtl/rxp_pack_stage.sv
module rxp_pack_stage
  import rxp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  wide,
  input  logic                  samp_valid,
  input  logic [2*BYTE_W-1:0]   samp_data,
  input  logic                  hold_empty,
  output logic                  xfer,
  output logic [WORD_W-1:0]     xfer_word,
  output logic                  full
);
  localparam int HALF_W   = 2 * BYTE_W;
  localparam int N_BYTE   = lanes_per_word(WORD_W, BYTE_W);
  localparam int N_HALF   = lanes_per_word(WORD_W, HALF_W);
  localparam int CNT_W    = (N_BYTE > 1) ? $clog2(N_BYTE) : 1;

  logic [WORD_W-1:0] pack_q;
  logic [WORD_W-1:0] word_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_cnt;
  logic              full_q;
  logic              accept;
  logic              complete;

  assign last_cnt = wide ? CNT_W'(N_HALF - 1) : CNT_W'(N_BYTE - 1);
  assign accept   = samp_valid & ~full_q & ~clr;
  assign complete = accept & (cnt_q == last_cnt);

  // Little-endian lane insertion: the lane index is the sample count.
  always_comb begin
    word_n = pack_q;
    if (wide) begin
      for (int i = 0; i < N_HALF; i++) begin
        if (cnt_q == CNT_W'(i)) word_n[i*HALF_W +: HALF_W] = samp_data;
      end
    end else begin
      for (int i = 0; i < N_BYTE; i++) begin
        if (cnt_q == CNT_W'(i)) word_n[i*BYTE_W +: BYTE_W] = samp_data[BYTE_W-1:0];
      end
    end
  end

  assign xfer      = ~clr & hold_empty & (full_q | complete);
  assign xfer_word = full_q ? pack_q : word_n;
  assign full      = full_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      if (rst) pack_q <= '0;
    end else if (xfer) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (complete) begin
      pack_q <= word_n;
      cnt_q  <= '0;
      full_q <= 1'b1;
    end else if (accept) begin
      pack_q <= word_n;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R5: a waiting word sits with its lane counter rewound.
  assert_wait_cnt_zero_R5: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (cnt_q == '0));

  // R7: while the reader is busy, a waiting word ignores incoming samples.
  assert_wait_word_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (full_q && !clr && !hold_empty) |=> (full_q && $stable(pack_q)));

  // R11: an idle bus cycle leaves the lane counter alone.
  assert_idle_no_count_R11: assert property (@(posedge clk) disable iff (rst)
    (!samp_valid && !clr && !full_q && !xfer) |=> $stable(cnt_q));
endmodule

// File: rtl/rxp_hold_stage.sv
module rxp_hold_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data
);
  logic              valid_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_word;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R8: the packing stage never pushes into an occupied holding register.
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid_q);

  // R8: an unread word stays put.
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready && !clr) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                flush,
  input  logic                samp_valid,
  input  logic [2*BYTE_W-1:0] samp_data,
  output logic [WORD_W-1:0]   hold_data,
  output logic                hold_valid,
  input  logic                hold_ready,
  output logic                start_ok
);
  logic              clr;
  logic              xfer;
  logic [WORD_W-1:0] xfer_word;
  logic              pack_full;

  rxp_clear_ctl u_clear (
    .clk     (clk),
    .flush   (flush),
    .wide_in (wide_mode),
    .clr     (clr)
  );

  rxp_pack_stage #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .wide       (wide_mode),
    .samp_valid (samp_valid),
    .samp_data  (samp_data),
    .hold_empty (~hold_valid),
    .xfer       (xfer),
    .xfer_word  (xfer_word),
    .full       (pack_full)
  );

  rxp_hold_stage #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .load      (xfer),
    .load_word (xfer_word),
    .ready     (hold_ready),
    .valid     (hold_valid),
    .data      (hold_data)
  );

  // Decoded straight from the two occupancy flops.
  assign start_ok = ~(pack_full & hold_valid);

  // R9, R10: any clear leaves both stages empty.
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!hold_valid && start_ok));

  // R5: a read with nothing waiting leaves the holding register empty.
  assert_read_drains_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && hold_ready && !pack_full && !clr) |=> !hold_valid);
endmodule

// File: tb/rx_word_packer_bench.sv
module rx_word_packer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        flush = 1'b0;
  logic        samp_valid = 1'b0;
  logic [15:0] samp_data = '0;
  logic        hold_ready = 1'b0;
  logic [31:0] hold_data;
  logic        hold_valid;
  logic        start_ok;

  always #5 clk = ~clk;

  rx_word_packer u_rx_word_packer (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .flush(flush),
    .samp_valid(samp_valid), .samp_data(samp_data),
    .hold_data(hold_data), .hold_valid(hold_valid),
    .hold_ready(hold_ready), .start_ok(start_ok)
  );

  int     vectors = 0;
  int     fails = 0;
  int     cycles = 0;
  string  cur_req = "R1";

  // Behavioural reference: a queue of captured lanes plus two word slots.
  int unsigned lanes[$];
  bit          m_prev;
  bit          m_wait;
  bit [31:0]   m_wait_w;
  bit          m_hv;
  bit [31:0]   m_hold;
  bit          m_clr;
  bit          m_hv0;
  int          need;
  bit [31:0]   w;

  always @(posedge clk) begin
    if (rst) begin
      lanes.delete(); m_wait = 0; m_hv = 0; m_prev = wide_mode;
    end else begin
      m_clr  = flush || (wide_mode != m_prev);
      m_prev = wide_mode;
      if (m_clr) begin
        lanes.delete(); m_wait = 0; m_hv = 0;
      end else begin
        m_hv0 = m_hv;
        if (m_wait) begin
          if (!m_hv0) begin m_hold = m_wait_w; m_hv = 1; m_wait = 0; end
        end else if (samp_valid) begin
          lanes.push_back(wide_mode ? samp_data : {8'h00, samp_data[7:0]});
          need = wide_mode ? 2 : 4;
          if (lanes.size() == need) begin
            w = 0;
            foreach (lanes[i]) w = w | (lanes[i] << (i * (wide_mode ? 16 : 8)));
            lanes.delete();
            if (!m_hv0) begin m_hold = w; m_hv = 1; end
            else begin m_wait = 1; m_wait_w = w; end
          end
        end
        if (m_hv0 && hold_ready) m_hv = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "hold_valid", {31'b0, hold_valid}, {31'b0, m_hv});
      chk(cur_req, "start_ok", {31'b0, start_ok}, {31'b0, !(m_wait && m_hv)});
      if (m_hv) chk(cur_req, "hold_data", hold_data, m_hold);
    end
  end

  task automatic drive(input bit v, input logic [15:0] d, input bit rdy, input bit fl, input bit wd);
    @(negedge clk);
    samp_valid = v; samp_data = d; hold_ready = rdy; flush = fl; wide_mode = wd;
  endtask

  task automatic settle();
    drive(0, 16'hdead, 0, 0, wide_mode);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset hold_valid", {31'b0, hold_valid}, 32'd0);
    chk("R1", "reset start_ok", {31'b0, start_ok}, 32'd1);

    // R2 and R4: bytes with junk above bit 7, word visible right after the last.
    cur_req = "R2";
    drive(1, 16'hA511, 0, 0, 0);
    drive(1, 16'h5A22, 0, 0, 0);
    drive(1, 16'hFF33, 0, 0, 0);
    drive(1, 16'h0044, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R4", "valid after last byte", {31'b0, hold_valid}, 32'd1);
    chk("R2", "byte packing", hold_data, 32'h44332211);

    // R6 and R7: fill the packing stage, then offer a byte that must vanish.
    cur_req = "R6";
    drive(1, 16'h00A1, 0, 0, 0);
    drive(1, 16'h00B2, 0, 0, 0);
    drive(1, 16'h00C3, 0, 0, 0);
    drive(1, 16'h00D4, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R6", "stall when both full", {31'b0, start_ok}, 32'd0);
    cur_req = "R7";
    drive(1, 16'h00EE, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R7", "held word intact", hold_data, 32'h44332211);

    // R5: one-cycle read pulse, gap, then the waiting word.
    cur_req = "R5";
    drive(0, 16'h0000, 1, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R5", "gap after read", {31'b0, hold_valid}, 32'd0);
    @(negedge clk);
    chk("R5", "waiting word loaded", {31'b0, hold_valid}, 32'd1);
    chk("R7", "dropped byte absent", hold_data, 32'hD4C3B2A1);
    chk("R6", "stall released", {31'b0, start_ok}, 32'd1);

    // R8: the word leaves once.
    cur_req = "R8";
    drive(0, 16'h0000, 1, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R8", "single handover", {31'b0, hold_valid}, 32'd0);

    // R10 then R3: switch to halfwords.
    cur_req = "R3";
    drive(0, 16'h0000, 0, 0, 1);
    drive(1, 16'hBEEF, 0, 0, 1);
    drive(1, 16'hDEAD, 0, 0, 1);
    drive(0, 16'h0000, 0, 0, 1);
    chk("R3", "halfword packing", hold_data, 32'hDEADBEEF);

    // R9: flush with a sample at the same edge, partial discarded.
    cur_req = "R9";
    drive(1, 16'h7777, 0, 0, 1);
    drive(1, 16'h8888, 0, 1, 1);
    drive(0, 16'h0000, 0, 0, 1);
    chk("R9", "flush clears held word", {31'b0, hold_valid}, 32'd0);
    drive(1, 16'h1111, 0, 0, 1);
    drive(1, 16'h2222, 0, 0, 1);
    drive(0, 16'h0000, 0, 0, 1);
    chk("R9", "restart at lane 0", hold_data, 32'h22221111);

    // R10: partial halfword discarded by a mode change.
    cur_req = "R10";
    drive(0, 16'h0000, 1, 0, 1);
    drive(1, 16'h9999, 0, 0, 1);
    drive(1, 16'h0001, 0, 0, 0);
    drive(1, 16'h0002, 0, 0, 0);
    drive(1, 16'h0003, 0, 0, 0);
    drive(1, 16'h0004, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R10", "mode change restarts", {31'b0, hold_valid}, 32'd0);
    drive(1, 16'h0005, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R10", "word after mode change", hold_data, 32'h05040302);

    // R11: idle cycles with junk data change nothing.
    cur_req = "R11";
    drive(0, 16'h0000, 1, 0, 0);
    drive(1, 16'h0010, 0, 0, 0);
    for (int i = 0; i < 5; i++) drive(0, 16'hFFFF, 0, 0, 0);
    drive(1, 16'h0020, 0, 0, 0);
    drive(1, 16'h0030, 0, 0, 0);
    drive(1, 16'h0040, 0, 0, 0);
    drive(0, 16'h0000, 0, 0, 0);
    chk("R11", "idle leaves packing", hold_data, 32'h40302010);

    // R8: random traffic compared every cycle against the model.
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) != 0, 16'($urandom), ($urandom % 3) == 0,
            ($urandom % 97) == 0, (($urandom % 131) == 0) ? ~wide_mode : wide_mode);
    end
    settle();
    finish_run();
  end
endmodule